// File: doc/BRIEF.md
# Special Function Register Access Unit

This unit holds a special-function register space of 16-bit registers split into two areas, a standard one and an extended one, and services single read and write accesses to it. Each access carries an addressing-mode tag that says whether it arrived through a full memory address, a short register address or an event-controller byte transfer. The tag, together with the access size, decides which bytes of the target register change and which are forced to zero. A separate bit-field write path changes only the bits selected by a mask in one byte and keeps every other bit.

Short register addresses carry only a word index. They land in the standard area unless an extension window is open. A window is armed with a length of one to four accesses and closes by itself once that many accesses have been made. Every register carries a computed mask of reserved positions. Those positions always read as zero and are never stored. Indices above the implemented range read as zero and ignore writes.

Top module: `sfr_access_unit`

## Requirements
- R1: After reset every implemented register holds zero, and `rd_valid` is low until the first read.
- R2: With mode tag 0 (full memory address) or 2 (event transfer), `req_addr[9]` selects the area (1 = extended), `req_addr[8:1]` is the word index and `req_addr[0]` the byte (1 = high). A read returns the whole word on `rd_data` one clock after the request.
- R3: With mode tag 1 (short register address), `req_addr[7:0]` is the word index. The access targets the standard area unless the extension window is open.
- R4: `ext_start` with `ext_len` = n opens the window for n+1 accesses. An access in the same cycle as `ext_start` is already inside the window and uses one of them. Cycles with no access do not shorten it, and the window closes after the last access.
- R5: A word write (`req_word`=1, `req_bitfld`=0) replaces all non-reserved bits with `req_wdata`.
- R6: A byte write with mode 0 or 2 stores `req_wdata[7:0]` in the addressed byte and forces the other byte to zero.
- R7: A byte write with mode 1 stores `req_wdata[7:0]` in the low byte and forces the high byte to zero.
- R8: A bit-field write (`req_bitfld`=1) targets the high byte when `req_bf_hi`=1 and the low byte otherwise. Bits set in `req_bmask` take the matching bits of `req_wdata[7:0]`, and every other bit of the word is kept.
- R9: The reserved positions are bits 15:12 in every word whose index has its two lowest bits equal to 3, plus bit 7 in every word of the extended area. They read as zero and writes to them are dropped.
- R10: Indices at or above `IMPL_WORDS` (default 16) read as zero and are left unchanged by writes, and such writes touch no other register.
- R11: `rd_valid` is high for exactly the one cycle after a read request, and low after a write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word size, 0 = byte size |
| req_mode | input | 2 | Addressing tag: 0 memory, 1 short register, 2 event transfer |
| req_bitfld | input | 1 | Masked bit-field write |
| req_bf_hi | input | 1 | Bit-field targets the high byte |
| req_addr | input | 10 | Access address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 8 | Bit-field mask |
| ext_start | input | 1 | Open the extension window |
| ext_len | input | 2 | Window length minus one |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 16 | Read data |

## Verification
Opening the extension window and making an access can fall in the same clock cycle. The rule is that this access is already steered to the extended area and uses one slot of the window. The bench raises `ext_start` together with a short-address write, then issues further short writes to the same index. It judges the outcome by memory-address reads of both areas: the first writes must land in the extended area, and the write after the window closes must land in the standard area. A second case opens a window during an idle cycle and checks that the idle cycle used none of the window's slots.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int SFR_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    AM_MEM  = 2'd0,
    AM_REG  = 2'd1,
    AM_XFER = 2'd2,
    AM_SPARE = 2'd3
  } sfr_mode_e;

  // Reserved positions: bits 15:12 when index[1:0]==3, bit 7 in the extended area.
  function automatic logic [SFR_W-1:0] rsv_mask(input logic area, input logic [1:0] idx_lo);
    logic [SFR_W-1:0] m;
    m = (idx_lo == 2'b11) ? 16'hF000 : 16'h0000;
    if (area) m = m | 16'h0080;
    return m;
  endfunction

  // Place a byte-wide value in the low or high byte of a word.
  function automatic logic [SFR_W-1:0] place_byte(input logic hi, input logic [BYTE_W-1:0] b);
    return hi ? {b, 8'h00} : {8'h00, b};
  endfunction

  // New register value for a write, before nothing else is applied.
  function automatic logic [SFR_W-1:0] merge_write(
    input logic [SFR_W-1:0]  old_v,
    input logic [SFR_W-1:0]  wdata,
    input logic              word,
    input sfr_mode_e         mode,
    input logic              bitfld,
    input logic              bf_hi,
    input logic              byte_sel,
    input logic [BYTE_W-1:0] bmask,
    input logic [SFR_W-1:0]  rsv
  );
    logic [SFR_W-1:0] v;
    logic [SFR_W-1:0] m16;
    if (bitfld) begin
      m16 = place_byte(bf_hi, bmask);
      v   = (old_v & ~m16) | (place_byte(bf_hi, wdata[7:0]) & m16);
    end else if (word) begin
      v = wdata;
    end else if (mode == AM_REG) begin
      v = place_byte(1'b0, wdata[7:0]);
    end else begin
      v = place_byte(byte_sel, wdata[7:0]);
    end
    return v & ~rsv;
  endfunction

endpackage

// File: rtl/sfr_ext_window.sv
module sfr_ext_window #(
  parameter int MAX_LEN = 4,
  localparam int LEN_W = $clog2(MAX_LEN),
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             ext_start,
  input  logic [LEN_W-1:0] ext_len,
  output logic             ext_active
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_d;

  assign base       = ext_start ? (CNT_W'(ext_len) + CNT_W'(1)) : cnt_q;
  assign ext_active = (base != '0);

  always_comb begin
    cnt_d = base;
    if (acc && base != '0) cnt_d = base - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_LEN));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ext_start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !ext_start) |=> $stable(cnt_q));

endmodule

// File: rtl/sfr_addr_decode.sv
module sfr_addr_decode #(
  parameter int AREA_WORDS = 256,
  parameter int IMPL_WORDS = 16,
  localparam int IDX_W  = $clog2(AREA_WORDS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  sfr_pkg::sfr_mode_e mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               ext_active,
  output logic               area,
  output logic [IDX_W-1:0]   idx,
  output logic               byte_sel,
  output logic               hit
);
  import sfr_pkg::*;

  always_comb begin
    if (mode == AM_REG) begin
      area     = ext_active;
      idx      = addr[IDX_W-1:0];
      byte_sel = 1'b0;
    end else begin
      area     = addr[ADDR_W-1];
      idx      = addr[IDX_W:1];
      byte_sel = addr[0];
    end
  end

  assign hit = ({1'b0, idx} < (IDX_W+1)'(IMPL_WORDS));

endmodule

// File: rtl/sfr_bank.sv
module sfr_bank #(
  parameter int AREA_WORDS = 256,
  parameter int IMPL_WORDS = 16,
  localparam int IDX_W  = $clog2(AREA_WORDS),
  localparam int IMPL_W = (IMPL_WORDS > 1) ? $clog2(IMPL_WORDS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     sel_area,
  input  logic [IDX_W-1:0]         sel_idx,
  input  logic                     sel_hit,
  input  logic [sfr_pkg::SFR_W-1:0] wval,
  output logic [sfr_pkg::SFR_W-1:0] cur_word
);
  import sfr_pkg::*;

  logic [SFR_W-1:0] mem_q [2][IMPL_WORDS];
  logic [IMPL_W-1:0] sel_lo;

  assign sel_lo   = IMPL_W'(sel_idx);
  assign cur_word = sel_hit ? mem_q[sel_area][sel_lo] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int w = 0; w < IMPL_WORDS; w++)
          mem_q[a][w] <= '0;
    end else if (wr_en && sel_hit) begin
      mem_q[sel_area][sel_lo] <= wval;
    end
  end

  for (genvar a = 0; a < 2; a++) begin : g_area
    for (genvar w = 0; w < IMPL_WORDS; w++) begin : g_word
      localparam logic [1:0] WLO = 2'(w);

      assert_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_hit && sel_area == 1'(a) && sel_idx == IDX_W'(w))
        |=> (mem_q[a][w] == $past(wval)));

      assert_rsv_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_q[a][w] & rsv_mask(1'(a), WLO)) == '0);
    end
  end

endmodule

// File: rtl/sfr_access_unit.sv
module sfr_access_unit #(
  parameter int AREA_WORDS = 256,
  parameter int IMPL_WORDS = 16,
  parameter int MAX_LEN    = 4,
  localparam int IDX_W  = $clog2(AREA_WORDS),
  localparam int ADDR_W = IDX_W + 2,
  localparam int LEN_W  = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [1:0]        req_mode,
  input  logic              req_bitfld,
  input  logic              req_bf_hi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [7:0]        req_bmask,
  input  logic              ext_start,
  input  logic [LEN_W-1:0]  ext_len,
  output logic              rd_valid,
  output logic [15:0]       rd_data
);
  import sfr_pkg::*;

  sfr_mode_e        mode;
  logic             ext_active;
  logic             area;
  logic [IDX_W-1:0] idx;
  logic             byte_sel;
  logic             hit;
  logic [SFR_W-1:0] cur_word;
  logic [SFR_W-1:0] rsv;
  logic [SFR_W-1:0] wval;
  logic [SFR_W-1:0] bf_m16;
  logic             wr_ev;
  logic             rd_ev;
  logic             miss_q;

  assign mode   = sfr_mode_e'(req_mode);
  assign wr_ev  = req_valid && req_we && hit;
  assign rd_ev  = req_valid && !req_we;
  assign rsv    = rsv_mask(area, idx[1:0]);
  assign bf_m16 = place_byte(req_bf_hi, req_bmask);

  sfr_ext_window #(.MAX_LEN(MAX_LEN)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc        (req_valid),
    .ext_start  (ext_start),
    .ext_len    (ext_len),
    .ext_active (ext_active)
  );

  sfr_addr_decode #(.AREA_WORDS(AREA_WORDS), .IMPL_WORDS(IMPL_WORDS)) u_dec (
    .mode       (mode),
    .addr       (req_addr),
    .ext_active (ext_active),
    .area       (area),
    .idx        (idx),
    .byte_sel   (byte_sel),
    .hit        (hit)
  );

  assign wval = merge_write(cur_word, req_wdata, req_word, mode, req_bitfld,
                            req_bf_hi, byte_sel, req_bmask, rsv);

  sfr_bank #(.AREA_WORDS(AREA_WORDS), .IMPL_WORDS(IMPL_WORDS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ev),
    .sel_area (area),
    .sel_idx  (idx),
    .sel_hit  (hit),
    .wval     (wval),
    .cur_word (cur_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      miss_q   <= 1'b0;
    end else begin
      rd_valid <= rd_ev;
      if (rd_ev) begin
        rd_data <= cur_word & ~rsv;
        miss_q  <= !hit;
      end
    end
  end

  // Bit-field writes leave every unselected bit of the word alone.
  assert_bitfield_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && req_bitfld) |-> (((wval ^ cur_word) & ~bf_m16) == '0));

  // Short-address byte writes clear the high byte.
  assert_short_hi_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && mode == AM_REG && !req_word && !req_bitfld) |-> (wval[15:8] == 8'h00));

  // Memory or transfer byte writes clear the non-addressed byte.
  assert_other_byte_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && mode != AM_REG && !req_word && !req_bitfld)
    |-> ((byte_sel ? wval[7:0] : wval[15:8]) == 8'h00));

  assert_unimpl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && miss_q) |-> (rd_data == '0));

  assert_rdvalid_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> !rd_valid);

  assert_read_rsv_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ev |=> ((rd_data & $past(rsv)) == '0));

endmodule

// File: tb/sfr_access_unit_test.sv
module sfr_access_unit_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0]  mode;
    logic        word;
    logic        bf;
    logic        bfhi;
    logic [9:0]  addr;
    logic [15:0] wdata;
    logic [7:0]  mask;
    logic [9:0]  raddr;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Each vector: one write, then a memory-mode word read of raddr.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h002, 16'hABCD, 8'h00, 10'h002, 16'hABCD, 4'd5},  // R5 word
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h006, 16'hFFFF, 8'h00, 10'h006, 16'h0FFF, 4'd9},  // R9 idx 3
    '{2'd0, 1'b0, 1'b0, 1'b0, 10'h003, 16'h0055, 8'h00, 10'h002, 16'h5500, 4'd6},  // R6 high byte
    '{2'd0, 1'b0, 1'b0, 1'b0, 10'h204, 16'h12A5, 8'h00, 10'h204, 16'h0025, 4'd6},  // R6 + ext rsv
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h008, 16'h1234, 8'h00, 10'h008, 16'h1234, 4'd5},  // R5
    '{2'd0, 1'b0, 1'b1, 1'b1, 10'h008, 16'h00A5, 8'hF0, 10'h008, 16'hA234, 4'd8},  // R8 high
    '{2'd0, 1'b0, 1'b1, 1'b0, 10'h008, 16'h00FF, 8'h0F, 10'h008, 16'hA23F, 4'd8},  // R8 low
    '{2'd1, 1'b0, 1'b0, 1'b0, 10'h005, 16'h7788, 8'h00, 10'h00A, 16'h0088, 4'd7},  // R7 short
    '{2'd2, 1'b0, 1'b0, 1'b0, 10'h00B, 16'h0099, 8'h00, 10'h00A, 16'h9900, 4'd6},  // R6 transfer
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h040, 16'hFFFF, 8'h00, 10'h040, 16'h0000, 4'd10}, // R10 unimpl
    '{2'd0, 1'b1, 1'b0, 1'b0, 10'h206, 16'hFFFF, 8'h00, 10'h206, 16'h0F7F, 4'd9},  // R9 ext idx 3
    '{2'd0, 1'b0, 1'b1, 1'b0, 10'h206, 16'h0000, 8'hFF, 10'h206, 16'h0F00, 4'd8}   // R8 on rsv word
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic        req_word = 1'b0;
  logic [1:0]  req_mode = 2'd0;
  logic        req_bitfld = 1'b0;
  logic        req_bf_hi = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_bmask = '0;
  logic        ext_start = 1'b0;
  logic [1:0]  ext_len = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  sfr_access_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_word(req_word), .req_mode(req_mode), .req_bitfld(req_bitfld),
    .req_bf_hi(req_bf_hi), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_bmask(req_bmask), .ext_start(ext_start), .ext_len(ext_len),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge; performs one access and returns at the next negedge.
  task automatic access(input logic we, input logic word, input logic [1:0] mode,
                        input logic bf, input logic bfhi, input logic [9:0] addr,
                        input logic [15:0] wd, input logic [7:0] mask,
                        input logic est, input logic [1:0] elen);
    req_valid = 1'b1; req_we = we; req_word = word; req_mode = mode;
    req_bitfld = bf; req_bf_hi = bfhi; req_addr = addr; req_wdata = wd;
    req_bmask = mask; ext_start = est; ext_len = elen;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; ext_start = 1'b0; req_bitfld = 1'b0;
  endtask

  task automatic mem_read(input logic [9:0] addr, output logic [15:0] val);
    access(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, addr, 16'h0, 8'h0, 1'b0, 2'd0);
    val = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R1 rd_valid after reset", {15'b0, rd_valid}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 rd_valid idle", {15'b0, rd_valid}, 16'h0000);
    mem_read(10'h002, v);
    check("R1 reset contents", v, 16'h0000);
    check("R11 rd_valid after read", {15'b0, rd_valid}, 16'h0001);
    mem_read(10'h206, v);
    check("R1 reset ext contents", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      access(1'b1, VEC[i].word, VEC[i].mode, VEC[i].bf, VEC[i].bfhi,
             VEC[i].addr, VEC[i].wdata, VEC[i].mask, 1'b0, 2'd0);
      if (i == 0) check("R11 rd_valid after write", {15'b0, rd_valid}, 16'h0000);
      mem_read(VEC[i].raddr, v);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].exp);
    end

    // R10: unimplemented write must not alias onto index 0.
    mem_read(10'h000, v);
    check("R10 no alias std idx0", v, 16'h0000);
    // R2: high byte of word read stays whole word.
    mem_read(10'h009, v);
    check("R2 odd address word read", v, 16'hA23F);
    // R3: short read of standard area.
    access(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 10'h004, 16'h0, 8'h0, 1'b0, 2'd0);
    check("R3 short read std idx4", rd_data, 16'hA23F);

    // R4: window of 2 opened together with the first access.
    access(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 10'h002, 16'h0011, 8'h0, 1'b1, 2'd1);
    access(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 10'h006, 16'h0022, 8'h0, 1'b0, 2'd0);
    access(1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 10'h006, 16'h0033, 8'h0, 1'b0, 2'd0);
    mem_read(10'h204, v);
    check("R4 same-cycle write in ext", v, 16'h0011);
    mem_read(10'h20C, v);
    check("R4 second write in ext", v, 16'h0022);
    mem_read(10'h00C, v);
    check("R4 window closed, std write", v, 16'h0033);

    // R4: window of 1 opened on an idle cycle; idle does not consume.
    ext_start = 1'b1; ext_len = 2'd0;
    @(negedge clk);
    ext_start = 1'b0;
    @(negedge clk);
    access(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 10'h002, 16'h0, 8'h0, 1'b0, 2'd0);
    check("R4 idle-armed short read ext", rd_data, 16'h0011);
    access(1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 10'h002, 16'h0, 8'h0, 1'b0, 2'd0);
    check("R3 short read std after window", rd_data, 16'h0000);

    // R1: reset clears storage again.
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mem_read(10'h008, v);
    check("R1 cleared after reset", v, 16'h0000);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule